// File: doc/BRIEF.md
# Sequence-Gated Poisoned Register File

This block holds register state for a pipeline that keeps running past a long memory miss and later replays the deferred, miss-dependent instructions. Each register of the main file keeps a data value, a poison vector (non-zero means the value is not yet known) and the sequence number of the last instruction that wrote it. A second, scratch file with its own poison vectors receives every replayed result, so a replay pass has somewhere to pass values between deferred instructions. One checkpoint of the main values can be taken and later restored.

During advance execution every write records its sequence number as the destination's last writer. A clean result writes the value and clears poison; a poisoned result only records its poison vector. During replay, a result is copied into the main file only if its sequence number still names the register's last writer, so a deferred instruction never overwrites a value produced by a logically younger one. Two combinational read ports each select the main or the scratch file.

Top module: `seqgate_regfile`

## Requirements
- R1: After reset every register of both files reads value 0 and poison vector 0 on both read ports.
- R2: The two read ports are independent and combinational; each returns value and poison of the addressed register, from the main file when its select is 0 and from the scratch file when it is 1.
- R3: An advance write with a zero poison vector stores its value into the main register, clears its poison and records its sequence number as last writer.
- R4: An advance write with a non-zero poison vector stores that vector as the main register's poison, leaves its value unchanged and records its sequence number as last writer.
- R5: A replay write with a zero poison vector whose sequence number equals the destination's last writer stores its value into the main register and clears its poison.
- R6: A replay write whose sequence number differs from the destination's last writer changes neither value nor poison of the main register.
- R7: Every replay write stores its value and poison vector into the scratch register, whether or not the main file accepts it.
- R8: A replay write with a non-zero poison vector never changes the main register, even with a matching sequence number.
- R9: A replay-start strobe clears the poison vector of every scratch register and keeps their values; a replay write in the same cycle lands after the clear.
- R10: A checkpoint create copies all main values; a restore puts those values back, clears all main poison and resets every last writer to 0.
- R11: A restore takes priority: advance and replay writes to the main file in the same cycle are dropped, and a create in the same cycle does not update the checkpoint.
- R12: When an advance write and a replay write hit the same register in one cycle, the advance sequence number becomes the last writer first and the replay is compared against it.
- R13: Sequence numbers are 10 bits wide and all 10 bits take part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_addr | input | 3 | Read port 0 register index |
| rd0_scr | input | 1 | Read port 0 file select (1 = scratch) |
| rd0_data | output | 16 | Read port 0 value |
| rd0_poison | output | 2 | Read port 0 poison vector |
| rd1_addr | input | 3 | Read port 1 register index |
| rd1_scr | input | 1 | Read port 1 file select (1 = scratch) |
| rd1_data | output | 16 | Read port 1 value |
| rd1_poison | output | 2 | Read port 1 poison vector |
| adv_we | input | 1 | Advance writeback enable |
| adv_addr | input | 3 | Advance destination register |
| adv_seq | input | 10 | Advance writer sequence number |
| adv_data | input | 16 | Advance result value |
| adv_poison | input | 2 | Advance result poison vector |
| rp_we | input | 1 | Replay writeback enable |
| rp_addr | input | 3 | Replay destination register |
| rp_seq | input | 10 | Replay writer sequence number |
| rp_data | input | 16 | Replay result value |
| rp_poison | input | 2 | Replay result poison vector (non-zero: load still pending) |
| ckpt_create | input | 1 | Take a checkpoint of main values |
| ckpt_restore | input | 1 | Restore main values from the checkpoint |
| replay_start | input | 1 | Begin a replay pass (clears scratch poison) |

## Verification
The bench aims at the ordering corners: a replay by an older writer after a younger poisoned write must be dropped, while the one matching the newest writer lands; a design that compared stale numbers or ignored the gate would let old data overwrite young state. It pairs sequence numbers that differ only in the top bit, which catches a truncated comparison, and a replay whose load is still pending, which a careless design would use to unpoison the main register. Same-cycle collisions are driven on purpose: advance and replay to one register (a design comparing against the old last writer accepts or drops the wrong one), restore against writes and against a create (a wrong priority leaves written data or a corrupted checkpoint), and replay-start against a replay write (the new poison would be lost). After a restore, a replay with sequence number 0 must land, which shows the last writers were reset.

// File: rtl/sgrf_pkg.sv
package sgrf_pkg;
    parameter int unsigned DATA_W   = 16;
    parameter int unsigned SEQ_W    = 10;
    parameter int unsigned PV_W     = 2;
    parameter int unsigned NUM_REGS = 8;
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [PV_W-1:0]   pv_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        data_t val;
        pv_t   pv;
        seq_t  lw;
    } main_ent_t;

    typedef struct packed {
        data_t val;
        pv_t   pv;
    } scr_ent_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        seq_t  seq;
        data_t data;
        pv_t   pv;
    } wr_req_t;

    function automatic logic is_poisoned(input pv_t v);
        return |v;
    endfunction
endpackage

// File: rtl/sgrf_gate.sv
module sgrf_gate
    import sgrf_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  main_ent_t cur,
    input  data_t     ckpt_val,
    input  wr_req_t   adv,
    input  wr_req_t   rp,
    input  logic      restore,
    output main_ent_t nxt
);
    logic adv_hit;
    logic rp_hit;
    seq_t lw_eff;
    logic rp_accept;

    always_comb begin
        adv_hit   = adv.we && (adv.addr == addr_t'(IDX));
        rp_hit    = rp.we && (rp.addr == addr_t'(IDX));
        // advance update of the last writer is seen by a same-cycle replay
        lw_eff    = adv_hit ? adv.seq : cur.lw;
        rp_accept = rp_hit && !restore && (rp.seq == lw_eff) && !is_poisoned(rp.pv);
        nxt = cur;
        if (restore) begin
            nxt.val = ckpt_val;
            nxt.pv  = '0;
            nxt.lw  = '0;
        end else begin
            if (adv_hit) begin
                nxt.lw = adv.seq;
                if (is_poisoned(adv.pv)) begin
                    nxt.pv = adv.pv;
                end else begin
                    nxt.val = adv.data;
                    nxt.pv  = '0;
                end
            end
            if (rp_accept) begin
                nxt.val = rp.data;
                nxt.pv  = '0;
            end
        end
    end
endmodule

// File: rtl/sgrf_main.sv
module sgrf_main
    import sgrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t adv,
    input  wr_req_t rp,
    input  logic    ckpt_create,
    input  logic    ckpt_restore,
    input  addr_t   rd0_addr,
    input  addr_t   rd1_addr,
    output data_t   rd0_val,
    output pv_t     rd0_pv,
    output data_t   rd1_val,
    output pv_t     rd1_pv
);
    main_ent_t ent_q [NUM_REGS];
    main_ent_t ent_d [NUM_REGS];
    data_t     ckpt_q [NUM_REGS];
    logic [NUM_REGS*PV_W-1:0] pv_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        sgrf_gate #(.IDX(g)) u_gate (
            .cur      (ent_q[g]),
            .ckpt_val (ckpt_q[g]),
            .adv      (adv),
            .rp       (rp),
            .restore  (ckpt_restore),
            .nxt      (ent_d[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g]  <= '0;
                ckpt_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
                if (ckpt_create && !ckpt_restore) begin
                    ckpt_q[g] <= ent_q[g].val;
                end
            end
        end

        assign pv_flat[g*PV_W +: PV_W] = ent_q[g].pv;
    end

    assign rd0_val = ent_q[rd0_addr].val;
    assign rd0_pv  = ent_q[rd0_addr].pv;
    assign rd1_val = ent_q[rd1_addr].val;
    assign rd1_pv  = ent_q[rd1_addr].pv;

    AST_RESTORE_CLEARS_POISON: assert property (@(posedge clk) disable iff (rst)
        ckpt_restore |=> (pv_flat == '0)); // R10

    AST_STALE_REPLAY_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (rp.we && !ckpt_restore && !(adv.we && adv.addr == rp.addr)
         && rp.seq != ent_q[rp.addr].lw)
        |=> (ent_q[$past(rp.addr)].val == $past(ent_q[rp.addr].val))
         && (ent_q[$past(rp.addr)].pv == $past(ent_q[rp.addr].pv))); // R6

    AST_MATCH_REPLAY_LANDS: assert property (@(posedge clk) disable iff (rst)
        (rp.we && !ckpt_restore && !is_poisoned(rp.pv)
         && !(adv.we && adv.addr == rp.addr) && rp.seq == ent_q[rp.addr].lw)
        |=> (ent_q[$past(rp.addr)].val == $past(rp.data))
         && (ent_q[$past(rp.addr)].pv == '0)); // R5

    AST_POISONED_ADV_KEEPS_VALUE: assert property (@(posedge clk) disable iff (rst)
        (adv.we && is_poisoned(adv.pv) && !ckpt_restore && !(rp.we && rp.addr == adv.addr))
        |=> (ent_q[$past(adv.addr)].val == $past(ent_q[adv.addr].val))); // R4
endmodule

// File: rtl/sgrf_scratch.sv
module sgrf_scratch
    import sgrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t rp,
    input  logic    replay_start,
    input  addr_t   rd0_addr,
    input  addr_t   rd1_addr,
    output data_t   rd0_val,
    output pv_t     rd0_pv,
    output data_t   rd1_val,
    output pv_t     rd1_pv
);
    scr_ent_t s_q [NUM_REGS];
    logic [NUM_REGS*PV_W-1:0] spv_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q[g] <= '0;
            end else if (rp.we && rp.addr == addr_t'(g)) begin
                s_q[g].val <= rp.data;
                s_q[g].pv  <= rp.pv;
            end else if (replay_start) begin
                s_q[g].pv <= '0;
            end
        end
        assign spv_flat[g*PV_W +: PV_W] = s_q[g].pv;
    end

    assign rd0_val = s_q[rd0_addr].val;
    assign rd0_pv  = s_q[rd0_addr].pv;
    assign rd1_val = s_q[rd1_addr].val;
    assign rd1_pv  = s_q[rd1_addr].pv;

    AST_START_CLEARS_SCRATCH: assert property (@(posedge clk) disable iff (rst)
        (replay_start && !rp.we) |=> (spv_flat == '0)); // R9

    AST_SCRATCH_CAPTURES_REPLAY: assert property (@(posedge clk) disable iff (rst)
        rp.we |=> (s_q[$past(rp.addr)].val == $past(rp.data))
               && (s_q[$past(rp.addr)].pv == $past(rp.pv))); // R7
endmodule

// File: rtl/seqgate_regfile.sv
module seqgate_regfile
    import sgrf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   rd0_addr,
    input  logic                rd0_scr,
    output logic [DATA_W-1:0]   rd0_data,
    output logic [PV_W-1:0]     rd0_poison,
    input  logic [ADDR_W-1:0]   rd1_addr,
    input  logic                rd1_scr,
    output logic [DATA_W-1:0]   rd1_data,
    output logic [PV_W-1:0]     rd1_poison,
    input  logic                adv_we,
    input  logic [ADDR_W-1:0]   adv_addr,
    input  logic [SEQ_W-1:0]    adv_seq,
    input  logic [DATA_W-1:0]   adv_data,
    input  logic [PV_W-1:0]     adv_poison,
    input  logic                rp_we,
    input  logic [ADDR_W-1:0]   rp_addr,
    input  logic [SEQ_W-1:0]    rp_seq,
    input  logic [DATA_W-1:0]   rp_data,
    input  logic [PV_W-1:0]     rp_poison,
    input  logic                ckpt_create,
    input  logic                ckpt_restore,
    input  logic                replay_start
);
    wr_req_t adv_req;
    wr_req_t rp_req;
    data_t   m0_val, m1_val, s0_val, s1_val;
    pv_t     m0_pv,  m1_pv,  s0_pv,  s1_pv;

    assign adv_req = '{we: adv_we, addr: adv_addr, seq: adv_seq, data: adv_data, pv: adv_poison};
    assign rp_req  = '{we: rp_we,  addr: rp_addr,  seq: rp_seq,  data: rp_data,  pv: rp_poison};

    sgrf_main u_main (
        .clk          (clk),
        .rst          (rst),
        .adv          (adv_req),
        .rp           (rp_req),
        .ckpt_create  (ckpt_create),
        .ckpt_restore (ckpt_restore),
        .rd0_addr     (rd0_addr),
        .rd1_addr     (rd1_addr),
        .rd0_val      (m0_val),
        .rd0_pv       (m0_pv),
        .rd1_val      (m1_val),
        .rd1_pv       (m1_pv)
    );

    sgrf_scratch u_scratch (
        .clk          (clk),
        .rst          (rst),
        .rp           (rp_req),
        .replay_start (replay_start),
        .rd0_addr     (rd0_addr),
        .rd1_addr     (rd1_addr),
        .rd0_val      (s0_val),
        .rd0_pv       (s0_pv),
        .rd1_val      (s1_val),
        .rd1_pv       (s1_pv)
    );

    assign rd0_data   = rd0_scr ? s0_val : m0_val;
    assign rd0_poison = rd0_scr ? s0_pv  : m0_pv;
    assign rd1_data   = rd1_scr ? s1_val : m1_val;
    assign rd1_poison = rd1_scr ? s1_pv  : m1_pv;
endmodule

// File: tb/test_seqgate_regfile.sv
module test_seqgate_regfile;
    import sgrf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ADDR_W-1:0] rd0_addr = '0, rd1_addr = '0;
    logic rd0_scr = 1'b0, rd1_scr = 1'b0;
    logic [DATA_W-1:0] rd0_data, rd1_data;
    logic [PV_W-1:0]   rd0_poison, rd1_poison;
    logic adv_we = 1'b0, rp_we = 1'b0;
    logic [ADDR_W-1:0] adv_addr = '0, rp_addr = '0;
    logic [SEQ_W-1:0]  adv_seq = '0, rp_seq = '0;
    logic [DATA_W-1:0] adv_data = '0, rp_data = '0;
    logic [PV_W-1:0]   adv_poison = '0, rp_poison = '0;
    logic ckpt_create = 1'b0, ckpt_restore = 1'b0, replay_start = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seqgate_regfile i_seqgate_regfile (
        .clk(clk), .rst(rst),
        .rd0_addr(rd0_addr), .rd0_scr(rd0_scr), .rd0_data(rd0_data), .rd0_poison(rd0_poison),
        .rd1_addr(rd1_addr), .rd1_scr(rd1_scr), .rd1_data(rd1_data), .rd1_poison(rd1_poison),
        .adv_we(adv_we), .adv_addr(adv_addr), .adv_seq(adv_seq), .adv_data(adv_data),
        .adv_poison(adv_poison),
        .rp_we(rp_we), .rp_addr(rp_addr), .rp_seq(rp_seq), .rp_data(rp_data),
        .rp_poison(rp_poison),
        .ckpt_create(ckpt_create), .ckpt_restore(ckpt_restore), .replay_start(replay_start)
    );

    typedef struct packed {
        logic        aw;
        logic [2:0]  aa;
        logic [9:0]  as;
        logic [15:0] ad;
        logic [1:0]  ap;
        logic        rw;
        logic [2:0]  ra;
        logic [9:0]  rs;
        logic [15:0] rd;
        logic [1:0]  rpv;
        logic [2:0]  ck;
        logic [15:0] ev;
        logic [1:0]  ep;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1, 1, 10'd5,   16'h1111, 2'd0, 0, 0, 10'd0,   16'h0000, 2'd0, 1, 16'h1111, 2'd0}, // R3
        '{1, 2, 10'd6,   16'hDEAD, 2'd1, 0, 0, 10'd0,   16'h0000, 2'd0, 2, 16'h0000, 2'd1}, // R4
        '{1, 2, 10'd9,   16'hBEEF, 2'd2, 0, 0, 10'd0,   16'h0000, 2'd0, 2, 16'h0000, 2'd2}, // R4
        '{0, 0, 10'd0,   16'h0000, 2'd0, 1, 2, 10'd6,   16'h2222, 2'd0, 2, 16'h0000, 2'd2}, // R6
        '{0, 0, 10'd0,   16'h0000, 2'd0, 1, 2, 10'd9,   16'h3333, 2'd0, 2, 16'h3333, 2'd0}, // R5
        '{1, 3, 10'h3FF, 16'h0F0F, 2'd1, 0, 0, 10'd0,   16'h0000, 2'd0, 3, 16'h0000, 2'd1}, // R4
        '{0, 0, 10'd0,   16'h0000, 2'd0, 1, 3, 10'h1FF, 16'h4444, 2'd0, 3, 16'h0000, 2'd1}, // R13
        '{0, 0, 10'd0,   16'h0000, 2'd0, 1, 3, 10'h3FF, 16'h5555, 2'd1, 3, 16'h0000, 2'd1}, // R8
        '{0, 0, 10'd0,   16'h0000, 2'd0, 1, 3, 10'h3FF, 16'h6666, 2'd0, 3, 16'h6666, 2'd0}, // R13
        '{1, 5, 10'd30,  16'h0000, 2'd1, 0, 0, 10'd0,   16'h0000, 2'd0, 5, 16'h0000, 2'd1}, // R4
        '{1, 5, 10'd31,  16'h0000, 2'd1, 1, 5, 10'd30,  16'h8888, 2'd0, 5, 16'h0000, 2'd1}, // R12
        '{1, 4, 10'd20,  16'h0000, 2'd1, 1, 4, 10'd20,  16'h7777, 2'd0, 4, 16'h7777, 2'd0}, // R12
        '{1, 1, 10'd40,  16'hAAAA, 2'd0, 0, 0, 10'd0,   16'h0000, 2'd0, 1, 16'hAAAA, 2'd0}  // R3
    };

    task automatic idle_inputs();
        adv_we = 0; adv_addr = '0; adv_seq = '0; adv_data = '0; adv_poison = '0;
        rp_we = 0; rp_addr = '0; rp_seq = '0; rp_data = '0; rp_poison = '0;
        ckpt_create = 0; ckpt_restore = 0; replay_start = 0;
    endtask

    // drive after a falling edge, let one rising edge take it, then release
    task automatic step(input logic aw, input int aa, input int as, input int ad, input int ap,
                        input logic rw, input int ra, input int rs, input int rd, input int rpv,
                        input logic cc, input logic cr, input logic rs_start);
        @(negedge clk);
        adv_we = aw; adv_addr = ADDR_W'(aa); adv_seq = SEQ_W'(as);
        adv_data = DATA_W'(ad); adv_poison = PV_W'(ap);
        rp_we = rw; rp_addr = ADDR_W'(ra); rp_seq = SEQ_W'(rs);
        rp_data = DATA_W'(rd); rp_poison = PV_W'(rpv);
        ckpt_create = cc; ckpt_restore = cr; replay_start = rs_start;
        @(posedge clk);
        #2;
        idle_inputs();
    endtask

    task automatic check(input int port, input logic scr, input int addr,
                         input int ev, input int ep, input string tag);
        logic [DATA_W-1:0] av;
        logic [PV_W-1:0] ap;
        if (port == 0) begin rd0_addr = ADDR_W'(addr); rd0_scr = scr; end
        else begin rd1_addr = ADDR_W'(addr); rd1_scr = scr; end
        #1;
        av = (port == 0) ? rd0_data : rd1_data;
        ap = (port == 0) ? rd0_poison : rd1_poison;
        checks++;
        if (av !== DATA_W'(ev) || ap !== PV_W'(ep)) begin
            failures++;
            $display("FAIL %s port%0d %s r%0d: got val=%h pv=%b, expected val=%h pv=%b",
                     tag, port, scr ? "scratch" : "main", addr, av, ap,
                     DATA_W'(ev), PV_W'(ep));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;

        // R1: everything clear after reset, on both ports and both files
        for (int r = 0; r < NUM_REGS; r++) begin
            check(0, 1'b0, r, 0, 0, "R1");
            check(1, 1'b1, r, 0, 0, "R1");
        end

        // table walk: R3 R4 R5 R6 R8 R12 R13 on the main file
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].aw, VECS[i].aa, VECS[i].as, VECS[i].ad, VECS[i].ap,
                 VECS[i].rw, VECS[i].ra, VECS[i].rs, VECS[i].rd, VECS[i].rpv,
                 1'b0, 1'b0, 1'b0);
            check(0, 1'b0, VECS[i].ck, VECS[i].ev, VECS[i].ep, $sformatf("vector%0d", i));
        end

        // R7 and R6: a rejected replay still fills scratch; R2 both ports at once
        step(0, 0, 0, 0, 0, 1, 6, 99, 'h9999, 2, 0, 0, 0);
        rd0_addr = 3'd6; rd0_scr = 1'b0;
        rd1_addr = 3'd6; rd1_scr = 1'b1;
        check(0, 1'b0, 6, 0, 0, "R6");
        check(1, 1'b1, 6, 'h9999, 2, "R7");
        check(0, 1'b0, 1, 'hAAAA, 0, "R2");
        check(1, 1'b1, 3, 'h6666, 0, "R2");

        // R9: replay start clears scratch poison, keeps values
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check(1, 1'b1, 6, 'h9999, 0, "R9");
        step(0, 0, 0, 0, 0, 1, 6, 99, 'h9999, 2, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 7, 1, 'h1234, 1, 0, 0, 1);
        check(1, 1'b1, 6, 'h9999, 0, "R9");
        check(1, 1'b1, 7, 'h1234, 1, "R9");
        check(0, 1'b0, 7, 0, 0, "R6");

        // R10: checkpoint create, overwrite, restore, last writer back to 0
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        step(1, 1, 50, 'hBBBB, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 2, 51, 'h0000, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        check(0, 1'b0, 1, 'hBBBB, 0, "R3");
        check(0, 1'b0, 2, 'h3333, 1, "R4");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        check(0, 1'b0, 1, 'hAAAA, 0, "R10");
        check(0, 1'b0, 2, 'h3333, 0, "R10");
        check(0, 1'b0, 5, 'h0000, 0, "R10");
        step(0, 0, 0, 0, 0, 1, 1, 0, 'hCCCC, 0, 0, 0, 0);
        check(0, 1'b0, 1, 'hCCCC, 0, "R10");

        // R11: restore beats a same-cycle advance write and a same-cycle create
        step(1, 3, 2, 'hEEEE, 0, 1, 1, 0, 'h5A5A, 0, 0, 1, 0);
        check(0, 1'b0, 3, 'h6666, 0, "R11");
        check(0, 1'b0, 1, 'hAAAA, 0, "R11");
        step(1, 3, 3, 'h1357, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check(0, 1'b0, 3, 'h1357, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        check(0, 1'b0, 3, 'h6666, 0, "R11");
        step(1, 3, 4, 'h2468, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        check(0, 1'b0, 3, 'h6666, 0, "R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule